// File: doc/BRIEF.md
# Slot Access Timeout Responder

This block sits beside the controller that runs cycles to three peripheral slots. Every slot cycle is announced by a one-cycle start strobe. From that strobe the block counts reference-clock cycles until the addressed slot acknowledges. If no acknowledge comes inside a fixed window, the block finishes the cycle itself. It drives a substitute acknowledge, so the host-side cycle always terminates.

A read that times out returns a data word of all ones. A write that times out is simply dropped: it is completed but not repeated. Each timeout also sets a sticky error flag, which software clears with a dedicated strobe. The flag is always recorded. The interrupt request only follows the flag while the interrupt enable is high, so masking the interrupt never loses the error.

The window length is the parameter `TIMEOUT_CYCLES`. Its default is 243 cycles of a 32 MHz reference, which is about 7.6 microseconds. Detection is permanently armed and has no disable.

Top module: `slot_timeout_responder`

## Requirements
- R1: While `rst_n` is low, `sub_ack`, `sub_rdata`, `berr_status` and `berr_irq` are all zero after the next clock edge.
- R2: If `slot_ack` is high in any of the `TIMEOUT_CYCLES` cycles that follow the cycle in which `cyc_start` was sampled, the access ends normally. No `sub_ack` pulse occurs for it and `berr_status` is unchanged.
- R3: If `slot_ack` stays low for all of those `TIMEOUT_CYCLES` cycles, `sub_ack` is high for exactly one cycle. That cycle is the (`TIMEOUT_CYCLES`+1)-th cycle after the start cycle.
- R4: During a `sub_ack` cycle for a read (`cyc_write` = 0 at the start strobe), `sub_rdata` is all ones. Whenever `sub_ack` is low, `sub_rdata` is zero.
- R5: A timed-out write (`cyc_write` = 1 at the start strobe) still produces the single `sub_ack` pulse, with `sub_rdata` zero. No second pulse follows.
- R6: A `slot_ack` in the last cycle of the window (the `TIMEOUT_CYCLES`-th cycle after the start cycle) counts as a normal completion, not a timeout.
- R7: `berr_status` rises in the same cycle as each `sub_ack` pulse, whatever the value of `berr_irq_en`. It then stays high until a cycle with `berr_clr` high, and is low from the next cycle.
- R8: When `berr_clr` is high in the cycle whose edge detects a timeout, `berr_status` is set, not cleared.
- R9: `berr_irq` equals `berr_status` AND `berr_irq_en` in every cycle, with no added delay.
- R10: A `cyc_start` that arrives while an access is still being timed is ignored and does not restart the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed reference clock for the timeout count |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-cycle strobe marking the start of a slot access |
| cyc_write | input | 1 | Direction of the access, sampled with `cyc_start` (1 = write) |
| slot_ack | input | 1 | Acknowledge from the addressed slot |
| berr_irq_en | input | 1 | Lets a latched error drive the interrupt request |
| berr_clr | input | 1 | Clears the sticky error flag |
| sub_ack | output | 1 | Substitute acknowledge after a timeout |
| sub_rdata | output | DATA_W | Substitute read data (all ones on a timed-out read) |
| berr_status | output | 1 | Sticky error flag |
| berr_irq | output | 1 | Interrupt request |

## Verification
The assertions check these behaviours on every cycle:
- `sub_ack` lines up with an independently counted window that honours ignored restarts and late acknowledges.
- A `sub_ack` pulse is one cycle wide.
- Read data is zero outside a pulse.
- The error flag is set with every pulse and holds until cleared.
- The interrupt tracks the flag and the enable.

Only the bench's scenarios show the following:
- All ones returned on a read and nothing on a write.
- A clear strobe that coincides with a timeout.
- The late-acknowledge boundary.
- An enable raised after the error has latched.

// File: rtl/slot_to_pkg.sv
// Package: shared constants and types for the slot access timeout responder.
// Assumes: nothing; it holds only parameter defaults and the FSM encoding.
package slot_to_pkg;

    // Default window: 243 cycles of a 32 MHz reference, about 7.6 us
    parameter int unsigned DEF_TIMEOUT_CYCLES = 243;

    // Default width of the substitute read data bus
    parameter int unsigned DEF_DATA_W = 32;

    // Timer state: idle, or timing an outstanding slot access
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_WAIT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/slot_to_timer.sv
// Module: slot_to_timer
// Times one outstanding slot access from its start strobe. It reports the
// cycle in which the window runs out with no acknowledge (hit_now), and
// registers that event, together with the access direction, for the
// response path.
// Assumes: cyc_start is a single-cycle strobe. A strobe while busy is ignored.
import slot_to_pkg::*;

module slot_to_timer #(
    parameter int unsigned TIMEOUT_CYCLES = DEF_TIMEOUT_CYCLES,
    parameter int unsigned CNT_W          = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic cyc_write,
    input  logic slot_ack,
    output logic hit_now,
    output logic expire_q,
    output logic expire_wr_q
);

    localparam logic [CNT_W-1:0] LAST_AGE = CNT_W'(TIMEOUT_CYCLES - 1);

    tmr_state_e       state_q;
    logic [CNT_W-1:0] age_q;
    logic             wr_q;

    // Expiry: still waiting, window used up, and no acknowledge this cycle
    always_comb begin
        hit_now = (state_q == TMR_WAIT) && !slot_ack && (age_q == LAST_AGE);
    end

    // Sequence idle/wait and age the outstanding access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            age_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            case (state_q)
                TMR_IDLE: begin
                    if (cyc_start) begin
                        state_q <= TMR_WAIT;
                        age_q   <= '0;
                        wr_q    <= cyc_write;
                    end
                end
                TMR_WAIT: begin
                    if (slot_ack || hit_now) begin
                        state_q <= TMR_IDLE;
                        age_q   <= '0;
                    end else begin
                        age_q   <= age_q + 1'b1;
                    end
                end
                default: state_q <= TMR_IDLE;
            endcase
        end
    end

    // Register the expiry event and its direction for the response path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire_q    <= 1'b0;
            expire_wr_q <= 1'b0;
        end else begin
            expire_q    <= hit_now;
            expire_wr_q <= hit_now && wr_q;
        end
    end

endmodule

// File: rtl/slot_to_resp.sv
// Module: slot_to_resp
// Forms the substitute completion from the registered expiry event. Reads
// return all ones; writes return zero data. The data bus is zero whenever
// no substitute acknowledge is being given.
// Assumes: expire_q is a single-cycle pulse from slot_to_timer.
module slot_to_resp #(
    parameter int unsigned DATA_W = slot_to_pkg::DEF_DATA_W
) (
    input  logic              expire_q,
    input  logic              expire_wr_q,
    output logic              sub_ack,
    output logic [DATA_W-1:0] sub_rdata
);

    // Drive acknowledge and data from the expiry pulse
    always_comb begin
        sub_ack   = expire_q;
        sub_rdata = (expire_q && !expire_wr_q) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    end

endmodule

// File: rtl/slot_to_status.sv
// Module: slot_to_status
// Holds the sticky bus-error flag and gates it onto the interrupt request.
// A new timeout takes priority over a clear in the same cycle.
// Assumes: hit_now is high for one cycle per timed-out access.
module slot_to_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_now,
    input  logic berr_clr,
    input  logic berr_irq_en,
    output logic berr_status,
    output logic berr_irq
);

    logic flag_q;

    // Set on a timeout, clear on the strobe; a timeout beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit_now) begin
            flag_q <= 1'b1;
        end else if (berr_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Expose the flag and mask it onto the interrupt request
    always_comb begin
        berr_status = flag_q;
        berr_irq    = flag_q && berr_irq_en;
    end

endmodule

// File: rtl/slot_timeout_responder.sv
// Module: slot_timeout_responder (top)
// Watches every slot access and completes any that the slot leaves
// unacknowledged for TIMEOUT_CYCLES reference cycles. It supplies default
// read data, latches a sticky error flag and raises a maskable interrupt.
// Assumes: clk is the fixed reference clock; rst_n is synchronous, active low.
import slot_to_pkg::*;

module slot_timeout_responder #(
    parameter int unsigned TIMEOUT_CYCLES = DEF_TIMEOUT_CYCLES,
    parameter int unsigned DATA_W         = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_write,
    input  logic              slot_ack,
    input  logic              berr_irq_en,
    input  logic              berr_clr,
    output logic              sub_ack,
    output logic [DATA_W-1:0] sub_rdata,
    output logic              berr_status,
    output logic              berr_irq
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);

    logic hit_now;
    logic expire_q;
    logic expire_wr_q;

    // Window timer
    slot_to_timer #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .CNT_W          (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .cyc_write   (cyc_write),
        .slot_ack    (slot_ack),
        .hit_now     (hit_now),
        .expire_q    (expire_q),
        .expire_wr_q (expire_wr_q)
    );

    // Substitute completion
    slot_to_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .expire_q    (expire_q),
        .expire_wr_q (expire_wr_q),
        .sub_ack     (sub_ack),
        .sub_rdata   (sub_rdata)
    );

    // Sticky error flag and interrupt
    slot_to_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_now     (hit_now),
        .berr_clr    (berr_clr),
        .berr_irq_en (berr_irq_en),
        .berr_status (berr_status),
        .berr_irq    (berr_irq)
    );

endmodule

// File: rtl/slot_timeout_responder_chk.sv
// Module: slot_timeout_responder_chk
// Property checker bound to the top. It keeps its own count of the
// acknowledge window and watches only the top-level ports.
// Assumes: the same parameters as the bound instance.
module slot_timeout_responder_chk #(
    parameter int unsigned TIMEOUT_CYCLES = slot_to_pkg::DEF_TIMEOUT_CYCLES,
    parameter int unsigned DATA_W         = slot_to_pkg::DEF_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_start,
    input logic              slot_ack,
    input logic              berr_irq_en,
    input logic              berr_clr,
    input logic              sub_ack,
    input logic [DATA_W-1:0] sub_rdata,
    input logic              berr_status,
    input logic              berr_irq
);

    logic        win_busy;
    int unsigned win_age;
    logic        win_due;

    // Independent window tracker: first start opens the window, an acknowledge or a full window closes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_busy <= 1'b0;
            win_age  <= 0;
            win_due  <= 1'b0;
        end else begin
            win_due <= 1'b0;
            if (!win_busy) begin
                if (cyc_start) begin
                    win_busy <= 1'b1;
                    win_age  <= 1;
                end
            end else if (slot_ack) begin
                win_busy <= 1'b0;
            end else if (win_age == TIMEOUT_CYCLES) begin
                win_busy <= 1'b0;
                win_due  <= 1'b1;
            end else begin
                win_age <= win_age + 1;
            end
        end
    end

    // R3
    sub_ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_ack == win_due);

    // R3
    sub_ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_ack |=> !sub_ack);

    // R4
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_ack |-> (sub_rdata == '0));

    // R7
    status_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_ack |-> berr_status);

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_status && !berr_clr) |=> berr_status);

    // R9
    irq_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_irq == (berr_status && berr_irq_en));

endmodule

bind slot_timeout_responder slot_timeout_responder_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .DATA_W         (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .slot_ack    (slot_ack),
    .berr_irq_en (berr_irq_en),
    .berr_clr    (berr_clr),
    .sub_ack     (sub_ack),
    .sub_rdata   (sub_rdata),
    .berr_status (berr_status),
    .berr_irq    (berr_irq)
);

// File: tb/slot_timeout_responder_bench.sv
// Bench: a behavioural reference model, compared with the DUT on every negedge, plus directed scenarios.
module slot_timeout_responder_bench;

    localparam int T  = 243;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0;
    logic          cyc_write = 1'b0;
    logic          slot_ack = 1'b0;
    logic          berr_irq_en = 1'b0;
    logic          berr_clr = 1'b0;
    logic          sub_ack;
    logic [DW-1:0] sub_rdata;
    logic          berr_status;
    logic          berr_irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    bit          m_busy = 0;
    int          m_age  = 0;
    bit          m_wr   = 0;
    bit          exp_ack = 0;
    logic [DW-1:0] exp_data = '0;
    bit          exp_status = 0;

    always #2 clk = ~clk;

    slot_timeout_responder #(.TIMEOUT_CYCLES(T), .DATA_W(DW)) u_slot_timeout_responder (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_write(cyc_write),
        .slot_ack(slot_ack), .berr_irq_en(berr_irq_en), .berr_clr(berr_clr),
        .sub_ack(sub_ack), .sub_rdata(sub_rdata), .berr_status(berr_status),
        .berr_irq(berr_irq)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model of the requirements, advanced at each edge
    always @(posedge clk) begin
        bit timeout;
        timeout = 0;
        if (!rst_n) begin
            m_busy = 0; m_age = 0; exp_ack = 0; exp_data = '0; exp_status = 0;
        end else begin
            exp_ack  = 0;
            exp_data = '0;
            if (m_busy) begin
                if (slot_ack) m_busy = 0;
                else if (m_age == T) begin
                    m_busy = 0; timeout = 1; exp_ack = 1;
                    exp_data = m_wr ? '0 : '1;
                end else m_age++;
            end else if (cyc_start) begin
                m_busy = 1; m_age = 1; m_wr = cyc_write;
            end
            if (timeout) exp_status = 1;
            else if (berr_clr) exp_status = 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(sub_ack == exp_ack, "R3/R2 sub_ack model", DW'(sub_ack), DW'(exp_ack));
            check(sub_rdata == exp_data, "R4/R5 sub_rdata model", sub_rdata, exp_data);
            check(berr_status == exp_status, "R7/R8 status model", DW'(berr_status), DW'(exp_status));
            check(berr_irq == (exp_status && berr_irq_en), "R9 irq model", DW'(berr_irq), DW'(exp_status && berr_irq_en));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic start_access(input bit wr);
        cyc_start = 1; cyc_write = wr;
        step();
        cyc_start = 0; cyc_write = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) step();
        check(!sub_ack && sub_rdata == '0 && !berr_status && !berr_irq, "R1 reset outputs",
              {sub_ack, berr_status, berr_irq}, 0);
        rst_n = 1; berr_irq_en = 1;
        step();

        // R2 early acknowledge
        start_access(0);
        repeat (4) step();
        slot_ack = 1; step(); slot_ack = 0;
        check(!berr_status && !sub_ack, "R2 early ack no error", DW'(berr_status), 0);
        repeat (3) step();

        // R3 / R4 read timeout
        start_access(0);
        repeat (T - 1) step();
        check(!sub_ack, "R3 no ack before window ends", DW'(sub_ack), 0);
        step();
        check(sub_ack, "R3 sub_ack at window end", DW'(sub_ack), 1);
        check(sub_rdata == '1, "R4 read data all ones", sub_rdata, '1);
        check(berr_status && berr_irq, "R7 status and irq set", {berr_status, berr_irq}, 3);
        step();
        check(!sub_ack && sub_rdata == '0, "R3 pulse one cycle", DW'(sub_ack), 0);

        // R7 clear
        berr_clr = 1; step(); berr_clr = 0;
        check(!berr_status, "R7 clear", DW'(berr_status), 0);

        // R5 write timeout with irq masked, R9 late enable
        berr_irq_en = 0;
        start_access(1);
        repeat (T) step();
        check(sub_ack && sub_rdata == '0, "R5 write timeout data zero", sub_rdata, 0);
        check(berr_status && !berr_irq, "R9 masked irq keeps status", {berr_status, berr_irq}, 2);
        step();
        check(!sub_ack, "R5 no second pulse", DW'(sub_ack), 0);
        berr_irq_en = 1; #1;
        check(berr_irq, "R9 irq follows enable", DW'(berr_irq), 1);
        berr_clr = 1; step(); berr_clr = 0;

        // R6 acknowledge in the final window cycle
        start_access(0);
        repeat (T - 1) step();
        slot_ack = 1; step(); slot_ack = 0;
        check(!sub_ack && !berr_status, "R6 last-cycle ack normal", {sub_ack, berr_status}, 0);
        step();
        check(!sub_ack && !berr_status, "R6 no late pulse", {sub_ack, berr_status}, 0);

        // R8 clear in the same cycle as the timeout
        start_access(0);
        repeat (T - 1) step();
        berr_clr = 1; step(); berr_clr = 0;
        check(berr_status && sub_ack, "R8 timeout beats clear", {berr_status, sub_ack}, 3);
        berr_clr = 1; step(); berr_clr = 0;

        // R10 restart strobe while busy is ignored
        start_access(0);
        repeat (9) step();
        start_access(0);
        repeat (T - 11) step();
        check(!sub_ack, "R10 not yet expired", DW'(sub_ack), 0);
        step();
        check(sub_ack, "R10 original window kept", DW'(sub_ack), 1);
        repeat (T + 5) step();
        check(!sub_ack, "R10 no extra pulse", DW'(sub_ack), 0);

        finish_run();
    end

endmodule